// File: doc/BRIEF.md
# Clock-Synthesizer Indirect Register Window

This block keeps the divider settings of a clock synthesizer behind a narrow indirect window in one 32-bit clock control word. Byte lane 1 of the word holds a 6-bit register index and a write-enable flag. Byte lane 2 is a data window onto whichever synthesizer register that index selects.

Four registers sit behind the window: the reference divider, the memory-clock feedback divider, the video-clock feedback divider, and the video-clock post divider. The post divider holds the base-2 logarithm of its ratio, so 0 to 3 stand for divide by 1, 2, 4 or 8. All four values are driven continuously to a clock generator model.

To write a register, the host does three things in order:
1. Write the index with write-enable set.
2. Write the data byte.
3. Rewrite the index with write-enable clear.

To read a register, the host writes the index with write-enable clear and then reads byte lane 2.

Top module: `pllwin_top`

## Requirements
- R1: Out of reset, the index is 0 and write-enable is clear. The exported values are reference divider 0x21, memory-clock feedback 0x85, video-clock post log2 1 and video-clock feedback 0x40.
- R2: A write with `host_be[1]` set latches index = `host_wdata[15:10]` and write-enable = `host_wdata[9]`. Both read back in the same positions on `host_rdata`, and bit 8 always reads 0.
- R3: A data-lane write (`host_be[2]`) made while the latched write-enable is clear changes no register.
- R4: A data-lane write made while the latched write-enable is set loads `host_wdata[23:16]` into the selected register, visible one cycle later. When lanes 1 and 2 are written together, the data uses the index and write-enable latched before that write.
- R5: The register indices are: reference divider 2, memory-clock feedback 4, video-clock feedback 5, video-clock post 6.
- R6: The post divider keeps only data bits [1:0]. Its bits [7:2] read back as 0 and are dropped on write.
- R7: An index that selects no register reads 0 on `host_rdata[23:16]`, and a data write to it changes no register.
- R8: `host_rdata[7:0]` and `host_rdata[31:24]` always read 0, and writes to lanes 0 and 3 have no effect.
- R9: `host_rdata[23:16]` shows the currently selected register without delay, so a new index is readable in the cycle after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Write strobe for the control word |
| host_be | input | 4 | Byte-lane enables for the write |
| host_wdata | input | 32 | Control word write data |
| host_rdata | output | 32 | Control word read data |
| ref_div_o | output | 8 | Reference divider |
| mclk_fb_div_o | output | 8 | Memory-clock feedback divider |
| vclk_post_log2_o | output | POST_W | Video-clock post divider, log2 of ratio |
| vclk_fb_div_o | output | 8 | Video-clock feedback divider |

## Verification
The assertions check the following on every cycle:
- an index write lands in the latch;
- a data write with write-enable set lands in the addressed register;
- no register moves on a write with write-enable clear or on a write to another index;
- an unmapped index reads zero.

Only the bench's scenarios can show the rest. That covers the full three-step write and two-step read sequences, the ordering when lanes 1 and 2 are written together, truncation of the post divider, and the reset values on the exported outputs.

// File: rtl/pllwin_pkg.sv
package pllwin_pkg;
   localparam int unsigned CTRL_W   = 32;
   localparam int unsigned DATA_W   = 8;
   localparam int unsigned IDX_W    = 6;
   localparam int unsigned IDX_LSB  = 10;
   localparam int unsigned WE_BIT   = 9;
   localparam int unsigned DATA_LSB = 16;
   localparam int unsigned NUM_REGS = 4;
   typedef logic [IDX_W-1:0]  idx_t;
   typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/pllwin_sel.sv
module pllwin_sel
   import pllwin_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  upd_i,
   input  byte_t lane_i,
   output idx_t  idx_o,
   output logic  we_o
);
   localparam int unsigned LOC_IDX = IDX_LSB - 8;
   localparam int unsigned LOC_WE  = WE_BIT - 8;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_o <= '0;
         we_o  <= 1'b0;
      end else if (upd_i) begin
         idx_o <= lane_i[LOC_IDX +: IDX_W];
         we_o  <= lane_i[LOC_WE];
      end
   end

   a_r2_index_latch: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> (idx_o == $past(lane_i[7:2])) && (we_o == $past(lane_i[1])));
endmodule

// File: rtl/pllwin_reg.sv
module pllwin_reg
   import pllwin_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned RST   = 1,
   parameter int unsigned IDX   = 0
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_i,
   input  logic  we_i,
   input  idx_t  idx_i,
   input  byte_t data_i,
   output byte_t val_o,
   output logic  hit_o,
   output byte_t rd_o
);
   if (WIDTH < 1 || WIDTH > DATA_W) begin : g_bad_w
      $error("pllwin_reg: WIDTH out of range");
   end
   if (IDX >= (1 << IDX_W)) begin : g_bad_idx
      $error("pllwin_reg: IDX does not fit the index field");
   end
   if ((RST >> WIDTH) != 0 || RST == 0) begin : g_bad_rst
      $error("pllwin_reg: reset value must be nonzero and fit WIDTH");
   end

   localparam logic [WIDTH-1:0] RST_V = WIDTH'(RST);
   localparam idx_t             IDX_V = IDX_W'(IDX);

   logic [WIDTH-1:0] q;

   assign hit_o = (idx_i == IDX_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RST_V;
      else if (wr_i && we_i && hit_o)
         q <= data_i[WIDTH-1:0];
   end

   assign val_o = DATA_W'(q);
   assign rd_o  = hit_o ? val_o : '0;

   a_r4_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && we_i && hit_o) |=> (q == $past(data_i[WIDTH-1:0])));
   a_r3_we_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !we_i) |=> $stable(q));
   a_r7_other_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !hit_o) |=> $stable(q));
endmodule

// File: rtl/pllwin_top.sv
module pllwin_top
   import pllwin_pkg::*;
#(
   parameter int unsigned REF_IDX   = 2,
   parameter int unsigned MFB_IDX   = 4,
   parameter int unsigned VFB_IDX   = 5,
   parameter int unsigned VPOST_IDX = 6,
   parameter int unsigned REF_RST   = 'h21,
   parameter int unsigned MFB_RST   = 'h85,
   parameter int unsigned VFB_RST   = 'h40,
   parameter int unsigned VPOST_RST = 1,
   parameter int unsigned POST_W    = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [3:0]        host_be,
   input  logic [CTRL_W-1:0] host_wdata,
   output logic [CTRL_W-1:0] host_rdata,
   output logic [7:0]        ref_div_o,
   output logic [7:0]        mclk_fb_div_o,
   output logic [POST_W-1:0] vclk_post_log2_o,
   output logic [7:0]        vclk_fb_div_o
);
   localparam int unsigned REG_IDX [NUM_REGS] = '{REF_IDX, MFB_IDX, VFB_IDX, VPOST_IDX};
   localparam int unsigned REG_RST [NUM_REGS] = '{REF_RST, MFB_RST, VFB_RST, VPOST_RST};
   localparam int unsigned REG_W   [NUM_REGS] = '{DATA_W, DATA_W, DATA_W, POST_W};

   if (POST_W < 1 || POST_W > 3) begin : g_bad_post
      $error("pllwin_top: POST_W must be 1..3");
   end
   if (REF_IDX == MFB_IDX || REF_IDX == VFB_IDX || REF_IDX == VPOST_IDX ||
       MFB_IDX == VFB_IDX || MFB_IDX == VPOST_IDX || VFB_IDX == VPOST_IDX) begin : g_dup_idx
      $error("pllwin_top: register indices must be distinct");
   end

   idx_t  idx_q;
   logic  we_q;
   logic  data_wr;
   byte_t lane1;
   byte_t lane2;

   assign lane1   = host_wdata[15:8];
   assign lane2   = host_wdata[DATA_LSB +: DATA_W];
   assign data_wr = host_wr && host_be[2];

   pllwin_sel i_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .upd_i (host_wr && host_be[1]),
      .lane_i(lane1),
      .idx_o (idx_q),
      .we_o  (we_q)
   );

   byte_t [NUM_REGS-1:0] reg_val;
   byte_t [NUM_REGS-1:0] reg_rd;
   logic  [NUM_REGS-1:0] reg_hit;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      pllwin_reg #(
         .WIDTH(REG_W[g]),
         .RST  (REG_RST[g]),
         .IDX  (REG_IDX[g])
      ) i_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_i  (data_wr),
         .we_i  (we_q),
         .idx_i (idx_q),
         .data_i(lane2),
         .val_o (reg_val[g]),
         .hit_o (reg_hit[g]),
         .rd_o  (reg_rd[g])
      );
   end

   byte_t rd_sel;
   always_comb begin
      rd_sel = '0;
      for (int k = 0; k < NUM_REGS; k++) rd_sel |= reg_rd[k];
   end

   assign host_rdata = {8'h00, rd_sel, idx_q, we_q, 1'b0, 8'h00};

   assign ref_div_o        = reg_val[0];
   assign mclk_fb_div_o    = reg_val[1];
   assign vclk_fb_div_o    = reg_val[2];
   assign vclk_post_log2_o = reg_val[3][POST_W-1:0];

   a_r7_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_hit == '0) |-> (host_rdata[23:16] == 8'h00));
   a_r7_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_hit));
endmodule

// File: tb/test_pllwin_top.sv
module test_pllwin_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [3:0]  host_be = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic [7:0]  ref_div_o, mclk_fb_div_o, vclk_fb_div_o;
   logic [1:0]  vclk_post_log2_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [7:0] m_ref = 8'h21, m_mfb = 8'h85, m_vfb = 8'h40;
   logic [1:0] m_post = 2'd1;
   logic [5:0] m_idx = '0;
   logic       m_we  = 1'b0;

   always #4 clk = ~clk;

   pllwin_top i_pllwin_top (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_be(host_be),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ref_div_o(ref_div_o), .mclk_fb_div_o(mclk_fb_div_o),
      .vclk_post_log2_o(vclk_post_log2_o), .vclk_fb_div_o(vclk_fb_div_o)
   );

   function automatic logic [7:0] sel_val(input logic [5:0] i);
      case (i)
         6'd2:    return m_ref;
         6'd4:    return m_mfb;
         6'd5:    return m_vfb;
         6'd6:    return {6'b0, m_post};
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [31:0] exp_rdata();
      return {8'h00, sel_val(m_idx), m_idx, m_we, 1'b0, 8'h00};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " rdata"}, host_rdata, exp_rdata());
      chk({tag, " ref"},   {24'h0, ref_div_o}, {24'h0, m_ref});
      chk({tag, " mfb"},   {24'h0, mclk_fb_div_o}, {24'h0, m_mfb});
      chk({tag, " vfb"},   {24'h0, vclk_fb_div_o}, {24'h0, m_vfb});
      chk({tag, " post"},  {30'h0, vclk_post_log2_o}, {30'h0, m_post});
   endtask

   task automatic op(input string tag, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_be = be; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_be = '0;
      // data lane uses the index/enable latched before this write (R4)
      if (be[2] && m_we) begin
         case (m_idx)
            6'd2: m_ref  = d[23:16];
            6'd4: m_mfb  = d[23:16];
            6'd5: m_vfb  = d[23:16];
            6'd6: m_post = d[17:16];
            default: ;
         endcase
      end
      if (be[1]) begin
         m_idx = d[15:10];
         m_we  = d[9];
      end
      check_all(tag);
   endtask

   task automatic wr_idx(input string tag, input logic [5:0] i, input logic we);
      op(tag, 4'b0010, {16'h0, i, we, 1'b1, 8'h00});
   endtask

   task automatic wr_data(input string tag, input logic [7:0] d);
      op(tag, 4'b0100, {8'hFF, d, 16'hFFFF});
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check_all("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after release");

      // R5 / R4: three-step writes to each register
      wr_idx("R2 idx ref", 6'd2, 1'b1);  wr_data("R4 ref", 8'hA7);  wr_idx("R4 close ref", 6'd2, 1'b0);
      wr_idx("R5 idx mfb", 6'd4, 1'b1);  wr_data("R5 mfb", 8'h3C);  wr_idx("R5 close mfb", 6'd4, 1'b0);
      wr_idx("R5 idx vfb", 6'd5, 1'b1);  wr_data("R5 vfb", 8'hD2);  wr_idx("R5 close vfb", 6'd5, 1'b0);
      wr_idx("R5 idx post", 6'd6, 1'b1); wr_data("R6 post trunc", 8'hFE); wr_idx("R6 close post", 6'd6, 1'b0);
      // R9: two-step read, value visible the cycle after index write
      wr_idx("R9 read ref", 6'd2, 1'b0);
      chk("R9 ref readback", {24'h0, host_rdata[23:16]}, 32'hA7);
      wr_idx("R9 read post", 6'd6, 1'b0);
      chk("R6 post upper zero", {24'h0, host_rdata[23:16]}, 32'h02);
      // R3: data write with enable clear ignored
      wr_idx("R3 sel mfb", 6'd4, 1'b0);
      wr_data("R3 ignored", 8'h11);
      chk("R3 mfb unchanged", {24'h0, mclk_fb_div_o}, 32'h3C);
      // R7: unmapped index
      wr_idx("R7 sel unmapped", 6'd33, 1'b1);
      chk("R7 reads zero", {24'h0, host_rdata[23:16]}, 32'h0);
      wr_data("R7 write unmapped", 8'h99);
      wr_idx("R7 close", 6'd33, 1'b0);
      // R8: lanes 0 and 3
      op("R8 lanes 0/3", 4'b1001, 32'hFFFF_FFFF);
      chk("R8 lane zero", {host_rdata[31:24], host_rdata[7:0]}, 32'h0);
      // R4: lanes 1 and 2 together use the old latch
      wr_idx("R4 arm vfb", 6'd5, 1'b1);
      op("R4 same write", 4'b0110, {8'h0, 8'h5A, 6'd2, 1'b1, 1'b0, 8'h0});
      chk("R4 vfb got data", {24'h0, vclk_fb_div_o}, 32'h5A);
      chk("R4 ref untouched", {24'h0, ref_div_o}, 32'hA7);
      wr_idx("R4 disarm", 6'd2, 1'b0);

      for (int it = 0; it < 400; it++) begin
         logic [31:0] d;
         logic [5:0]  ix;
         d = $urandom;
         case ($urandom % 5)
            0: ix = 6'd2;
            1: ix = 6'd4;
            2: ix = 6'd5;
            3: ix = 6'd6;
            default: ix = 6'($urandom);
         endcase
         d[15:10] = ix;
         op("R4 random", 4'($urandom), d);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule